// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block holds the architectural registers of a processor that uses register windows for procedure calls. Thirty-two logical register numbers are visible at any time. Numbers 0 to 7 reach a bank of globals that is never remapped. The other 24 numbers reach three areas of the current window: incoming arguments (8 to 15), private locals (16 to 23) and outgoing arguments (24 to 31). The outgoing area of a window is the same storage as the incoming area of the next window. A caller therefore leaves arguments in its outgoing registers and the callee finds them in its incoming registers, with no data copied.

The windows form a ring. A current window pointer selects the active window, and an oldest pointer marks the deepest window still held in the ring; that window is the one a spill empties. The window just below it is the one the next fill refills. A call that would let the new window's outgoing area overwrite the oldest live window first raises an overflow trap and writes the oldest window's 16 private registers (incoming, then locals) to a memory stack, one register per handshake. A return from the oldest resident window while frames sit in memory raises an underflow trap and reads the frame back before the pointer moves. Both transfers use a valid/ready port. Memory slot `f*16 + n` holds register `n` of saved frame `f`, and frame 0 is the deepest.

Top module: `winreg_file`

## Requirements
- R1: After reset the current and oldest pointers are 0, `busy` is low, no trap is raised, `mem_valid` is low, and every register reads 0.
- R2: Logical numbers 0 to 7 select the global bank, which returns the same value whichever window is current.
- R3: A value written to outgoing register 24+n before a call is read from incoming register 8+n after the call, and the reverse holds after the return.
- R4: Locals (16 to 23) belong to one window only: a call shows a different set, and the return shows the caller's values again.
- R5: With no trap, a call raises `cwp` by one (modulo the window count) on the next clock, and a return lowers it by one.
- R6: A call when `cwp+2` equals the oldest pointer (modulo the window count) pulses `ovf_trap` in the first busy cycle and writes 16 words (`mem_write`=1) to addresses `saved*16 + n`, n = 0 to 15. The data is the oldest window's incoming registers then its locals. After the last accepted word, `cwp` and the oldest pointer each advance by one.
- R7: A return when `cwp` equals the oldest pointer, with at least one saved frame, pulses `unf_trap` in the first busy cycle and reads 16 words (`mem_write`=0) from `(saved-1)*16 + n` into the window below. After the last word, both pointers move down by one.
- R8: A return from the oldest resident window when no frame is saved changes nothing.
- R9: While `busy` is high, `call`, `ret` and `we` have no effect.
- R10: If `call` and `ret` are high in the same idle cycle, only the call acts.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` stay unchanged.
- R12: A call that needs a spill when the saved-frame count is at its maximum (2^SAVE_W - 1) is ignored: no trap, no pointer change.
- R13: A write (`we`) in an idle cycle stores `wd` into the register that `wa` names under the current window, even when a call or return acts in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call | input | 1 | Procedure call request |
| ret | input | 1 | Procedure return request |
| ra_addr | input | 5 | Logical number, read port A |
| ra_data | output | DW | Read data A (combinational) |
| rb_addr | input | 5 | Logical number, read port B |
| rb_data | output | DW | Read data B (combinational) |
| we | input | 1 | Write enable |
| wa | input | 5 | Logical number to write |
| wd | input | DW | Write data |
| cwp | output | log2(NWIN) | Current window pointer |
| swp | output | log2(NWIN) | Oldest resident window |
| busy | output | 1 | Spill or fill in progress |
| ovf_trap | output | 1 | Overflow trap pulse |
| unf_trap | output | 1 | Underflow trap pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | SAVE_W+4 | Word address in the save stack |
| mem_wdata | output | DW | Spill data |
| mem_ready | input | 1 | Memory accepts / returns data |
| mem_rdata | input | DW | Fill data, valid with `mem_ready` |

## Verification
The bench builds the block with four windows and SAVE_W = 2, and keeps the default eight registers per area and 32-bit data. With four windows, a nesting depth of three already forces a spill. Three saved frames fill the save stack, so the ignored call of R12 is reached within six nested calls. Random call, return and write traffic, together with a memory that stalls at random, keeps the ring wrapping. This drives spills and fills through every pointer value and stretches transfers with wait states.

// File: rtl/wf_pkg.sv
package wf_pkg;

  typedef enum logic [1:0] {
    WF_RUN   = 2'd0,
    WF_SPILL = 2'd1,
    WF_FILL  = 2'd2
  } wf_state_e;

  // Physical slot of a logical windowed register (lr >= nreg).
  // Outgoing area (section 3) lives in the next window's incoming area.
  function automatic int wf_phys(int cwp, int lr, int nwin, int nreg);
    int sect;
    int win;
    sect = lr / nreg;
    win  = (sect == 3) ? (cwp + 1) % nwin : cwp;
    return win * 2 * nreg + ((sect == 2) ? nreg : 0) + (lr % nreg);
  endfunction

endpackage

// File: rtl/wf_ctrl.sv
module wf_ctrl
  import wf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int FRAME  = 16,
  parameter int SAVE_W = 6,
  localparam int WPW   = $clog2(NWIN),
  localparam int FB    = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              mem_ready,
  output logic [WPW-1:0]    cwp,
  output logic [WPW-1:0]    swp,
  output logic [SAVE_W-1:0] saved,
  output logic [FB-1:0]     k,
  output wf_state_e         st,
  output logic              ovf_trap,
  output logic              unf_trap
);

  // Named internal events
  logic idle, ovf_hit, at_oldest, save_full, save_empty;
  logic call_go, ret_go, step_up, step_dn, spill_go, fill_go, xfer, last;

  assign idle       = (st == WF_RUN);
  assign ovf_hit    = (WPW'(cwp + WPW'(2)) == swp);
  assign at_oldest  = (cwp == swp);
  assign save_full  = &saved;
  assign save_empty = (saved == '0);
  assign call_go    = idle & call_i;
  assign ret_go     = idle & ret_i & ~call_i;
  assign step_up    = call_go & ~ovf_hit;
  assign step_dn    = ret_go & ~at_oldest;
  assign spill_go   = call_go & ovf_hit & ~save_full;
  assign fill_go    = ret_go & at_oldest & ~save_empty;
  assign xfer       = ~idle & mem_ready;
  assign last       = xfer & (k == FB'(FRAME - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= WF_RUN;
      cwp      <= '0;
      swp      <= '0;
      saved    <= '0;
      k        <= '0;
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
    end else begin
      ovf_trap <= spill_go;
      unf_trap <= fill_go;
      case (st)
        WF_RUN: begin
          k <= '0;
          if (step_up) cwp <= cwp + 1'b1;
          if (step_dn) cwp <= cwp - 1'b1;
          if (spill_go) st <= WF_SPILL;
          if (fill_go)  st <= WF_FILL;
        end
        WF_SPILL: if (xfer) begin
          k <= k + 1'b1;
          if (last) begin
            st    <= WF_RUN;
            cwp   <= cwp + 1'b1;
            swp   <= swp + 1'b1;
            saved <= saved + 1'b1;
          end
        end
        WF_FILL: if (xfer) begin
          k <= k + 1'b1;
          if (last) begin
            st    <= WF_RUN;
            cwp   <= cwp - 1'b1;
            swp   <= swp - 1'b1;
            saved <= saved - 1'b1;
          end
        end
        default: st <= WF_RUN;
      endcase
    end
  end

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cwp == '0 && swp == '0 && st == WF_RUN && !ovf_trap && !unf_trap));
  // R5: plain call / return step
  a_r5_call_step: assert property (@(posedge clk) disable iff (rst)
    step_up |=> cwp == WPW'($past(cwp) + 1'b1));
  a_r5_ret_step: assert property (@(posedge clk) disable iff (rst)
    step_dn |=> cwp == WPW'($past(cwp) - 1'b1));
  // R6: trap marks the start of a spill; ring never closes on itself
  a_r6_trap_start: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> (st == WF_SPILL && k == '0));
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    idle |-> (WPW'(cwp + 1'b1) != swp));
  // R7: trap marks the start of a fill
  a_r7_trap_start: assert property (@(posedge clk) disable iff (rst)
    unf_trap |-> (st == WF_FILL && k == '0));
  // R8: return at the outermost frame with nothing saved
  a_r8_outer_ret: assert property (@(posedge clk) disable iff (rst)
    (ret_go && at_oldest && save_empty) |=> ($stable(cwp) && $stable(saved) && st == WF_RUN));
  // R9: pointers hold while a transfer is under way
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (!idle && !last) |=> ($stable(cwp) && $stable(swp) && $stable(saved)));
  // R12: full save stack blocks the spill
  a_r12_full_ignored: assert property (@(posedge clk) disable iff (rst)
    (call_go && ovf_hit && save_full) |=> ($stable(cwp) && st == WF_RUN && !ovf_trap));

endmodule

// File: rtl/wf_store.sv
module wf_store
  import wf_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int NREG  = 8,
  parameter int DW    = 32,
  localparam int WPW  = $clog2(NWIN),
  localparam int RB   = $clog2(NREG),
  localparam int LW   = RB + 2,
  localparam int NPHYS = NWIN * 2 * NREG,
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WPW-1:0]         cwp,
  input  logic [1:0][LW-1:0]     rd_addr,
  output logic [1:0][DW-1:0]     rd_data,
  input  logic                   wr_en,
  input  logic [LW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   fill_en,
  input  logic [PW-1:0]          fill_idx,
  input  logic [DW-1:0]          fill_data,
  input  logic [PW-1:0]          spill_idx,
  output logic [DW-1:0]          spill_data
);

  logic [DW-1:0] glob [NREG];
  logic [DW-1:0] wins [NPHYS];

  logic          wr_glob;
  logic [PW-1:0] wr_idx;

  assign wr_glob = (wr_addr[LW-1:RB] == 2'd0);
  assign wr_idx  = PW'(wf_phys(int'(cwp), int'(wr_addr), NWIN, NREG));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++)  glob[i] <= '0;
      for (int i = 0; i < NPHYS; i++) wins[i] <= '0;
    end else if (fill_en) begin
      wins[fill_idx] <= fill_data;
    end else if (wr_en) begin
      if (wr_glob) glob[wr_addr[RB-1:0]] <= wr_data;
      else         wins[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [PW-1:0] idx;
    assign idx = PW'(wf_phys(int'(cwp), int'(rd_addr[p]), NWIN, NREG));
    assign rd_data[p] = (rd_addr[p][LW-1:RB] == 2'd0) ? glob[rd_addr[p][RB-1:0]] : wins[idx];
  end

  assign spill_data = wins[spill_idx];

  // R9: a fill and a user write never collide
  a_r9_one_writer: assert property (@(posedge clk) disable iff (rst)
    !(fill_en && wr_en));

endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import wf_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int NREG   = 8,
  parameter int DW     = 32,
  parameter int SAVE_W = 6,
  localparam int WPW   = $clog2(NWIN),
  localparam int RB    = $clog2(NREG),
  localparam int LW    = RB + 2,
  localparam int FRAME = 2 * NREG,
  localparam int FB    = $clog2(FRAME),
  localparam int PW    = WPW + FB,
  localparam int AW    = SAVE_W + FB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call,
  input  logic              ret,
  input  logic [LW-1:0]     ra_addr,
  output logic [DW-1:0]     ra_data,
  input  logic [LW-1:0]     rb_addr,
  output logic [DW-1:0]     rb_data,
  input  logic              we,
  input  logic [LW-1:0]     wa,
  input  logic [DW-1:0]     wd,
  output logic [WPW-1:0]    cwp,
  output logic [WPW-1:0]    swp,
  output logic              busy,
  output logic              ovf_trap,
  output logic              unf_trap,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata
);

  logic [SAVE_W-1:0] saved;
  logic [FB-1:0]     k;
  wf_state_e         st;
  logic [SAVE_W-1:0] slot;
  logic              user_we, fill_en;
  logic [PW-1:0]     spill_idx, fill_idx;
  logic [WPW-1:0]    below;

  wf_ctrl #(.NWIN(NWIN), .FRAME(FRAME), .SAVE_W(SAVE_W)) u_ctrl (
    .clk(clk), .rst(rst), .call_i(call), .ret_i(ret), .mem_ready(mem_ready),
    .cwp(cwp), .swp(swp), .saved(saved), .k(k), .st(st),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );

  assign busy      = (st != WF_RUN);
  assign user_we   = we & ~busy;
  assign fill_en   = (st == WF_FILL) & mem_ready;
  assign below     = swp - 1'b1;
  assign spill_idx = {swp, k};
  assign fill_idx  = {below, k};
  assign slot      = (st == WF_FILL) ? saved - 1'b1 : saved;

  assign mem_valid = busy;
  assign mem_write = (st == WF_SPILL);
  assign mem_addr  = {slot, k};

  wf_store #(.NWIN(NWIN), .NREG(NREG), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .cwp(cwp),
    .rd_addr({rb_addr, ra_addr}), .rd_data({rb_data, ra_data}),
    .wr_en(user_we), .wr_addr(wa), .wr_data(wd),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_data(mem_rdata),
    .spill_idx(spill_idx), .spill_data(mem_wdata)
  );

  // R11: request held stable until accepted
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write)));
  // R6: spill targets the next free stack slot, starting at offset 0
  a_r6_spill_addr: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> (mem_valid && mem_write && mem_addr[FB-1:0] == '0));

endmodule

// File: tb/sim_winreg_file.sv
module sim_winreg_file;

  localparam int NW = 4;
  localparam int R  = 8;
  localparam int F  = 2 * R;
  localparam int SW = 2;
  localparam int MAXS = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst;
  logic call, ret, we, mem_ready;
  logic [4:0] ra_addr, rb_addr, wa;
  logic [31:0] wd, mem_rdata, ra_data, rb_data, mem_wdata;
  logic [1:0] cwp, swp;
  logic busy, ovf_trap, unf_trap, mem_valid, mem_write;
  logic [SW+3:0] mem_addr;

  always #5 clk = ~clk;

  winreg_file #(.NWIN(NW), .NREG(R), .DW(32), .SAVE_W(SW)) u0 (
    .clk(clk), .rst(rst), .call(call), .ret(ret),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .we(we), .wa(wa), .wd(wd), .cwp(cwp), .swp(swp), .busy(busy),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int rdy_pct = 100;
  bit finished = 0;

  // Behavioural reference
  int m_cwp, m_swp, m_saved, m_mode, m_pos;
  bit m_ovf, m_unf;
  logic [31:0] g_m [R];
  logic [31:0] w_m [NW*F];
  logic [31:0] stack_m [int];

  function automatic int slot_of(int win, int lr);
    int area = lr / R;
    int owner = (area == 3) ? (win + 1) % NW : win;
    int part = (area == 2) ? R : 0;
    return owner * F + part + lr % R;
  endfunction

  function automatic logic [31:0] m_read(int lr);
    if (lr < R) return g_m[lr];
    return w_m[slot_of(m_cwp, lr)];
  endfunction

  function automatic logic [31:0] stk(int a);
    if (stack_m.exists(a)) return stack_m[a];
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string area_tag(int lr);
    if (lr < R)     return "R2 global read";
    if (lr < 2 * R) return "R3 incoming read";
    if (lr < 3 * R) return "R4 local read";
    return "R3 outgoing read";
  endfunction

  task automatic compare_all();
    chk(int'(cwp) == m_cwp, "R5 cwp", 32'(cwp), 32'(m_cwp));
    chk(int'(swp) == m_swp, "R6 oldest pointer", 32'(swp), 32'(m_swp));
    chk(busy == (m_mode != 0), "R9 busy", 32'(busy), 32'(m_mode != 0));
    chk(ovf_trap == m_ovf, "R6 ovf_trap", 32'(ovf_trap), 32'(m_ovf));
    chk(unf_trap == m_unf, "R7 unf_trap", 32'(unf_trap), 32'(m_unf));
    chk(mem_valid == (m_mode != 0), "R11 mem_valid", 32'(mem_valid), 32'(m_mode != 0));
    if (m_mode == 1) begin
      chk(mem_write == 1'b1, "R6 mem_write", 32'(mem_write), 32'd1);
      chk(int'(mem_addr) == m_saved * F + m_pos, "R6 spill address", 32'(mem_addr), 32'(m_saved * F + m_pos));
      chk(mem_wdata == w_m[m_swp * F + m_pos], "R6 spill data", mem_wdata, w_m[m_swp * F + m_pos]);
    end
    if (m_mode == 2) begin
      chk(mem_write == 1'b0, "R7 mem_write", 32'(mem_write), 32'd0);
      chk(int'(mem_addr) == (m_saved - 1) * F + m_pos, "R7 fill address", 32'(mem_addr), 32'((m_saved - 1) * F + m_pos));
    end
    chk(ra_data == m_read(int'(ra_addr)), area_tag(int'(ra_addr)), ra_data, m_read(int'(ra_addr)));
    chk(rb_data == m_read(int'(rb_addr)), area_tag(int'(rb_addr)), rb_data, m_read(int'(rb_addr)));
  endtask

  task automatic model_step(bit c, bit r, bit w, int a, logic [31:0] d, bit rdy);
    bit nov = 0;
    bit nun = 0;
    if (m_mode == 0) begin
      if (w) begin
        if (a < R) g_m[a] = d;
        else w_m[slot_of(m_cwp, a)] = d;
      end
      if (c) begin
        if ((m_cwp + 2) % NW == m_swp) begin
          if (m_saved < MAXS) begin m_mode = 1; m_pos = 0; nov = 1; end
        end else m_cwp = (m_cwp + 1) % NW;
      end else if (r) begin
        if (m_cwp == m_swp) begin
          if (m_saved > 0) begin m_mode = 2; m_pos = 0; nun = 1; end
        end else m_cwp = (m_cwp + NW - 1) % NW;
      end
    end else if (rdy) begin
      if (m_mode == 1) stack_m[m_saved * F + m_pos] = w_m[m_swp * F + m_pos];
      else w_m[((m_swp + NW - 1) % NW) * F + m_pos] = stk((m_saved - 1) * F + m_pos);
      if (m_pos == F - 1) begin
        if (m_mode == 1) begin
          m_cwp = (m_cwp + 1) % NW; m_swp = (m_swp + 1) % NW; m_saved++;
        end else begin
          m_cwp = (m_cwp + NW - 1) % NW; m_swp = (m_swp + NW - 1) % NW; m_saved--;
        end
        m_mode = 0;
      end else m_pos++;
    end
    m_ovf = nov;
    m_unf = nun;
  endtask

  // One clock: drive at the falling edge, compare, advance the model.
  task automatic tick(bit c, bit r, bit w, int a, logic [31:0] d);
    bit rdy;
    rdy = ($urandom % 100) < rdy_pct;
    call = c; ret = r; we = w; wa = 5'(a); wd = d;
    mem_ready = rdy;
    mem_rdata = stk(int'(mem_addr));
    ra_addr = 5'($urandom % 32);
    rb_addr = 5'($urandom % 32);
    #1;
    compare_all();
    model_step(c, r, w, a, d, rdy);
    @(negedge clk);
  endtask

  task automatic idle_until_free();
    while (m_mode != 0) tick(0, 0, 0, 0, 32'h0);
  endtask

  task automatic peek(int lr, output logic [31:0] v);
    call = 0; ret = 0; we = 0;
    ra_addr = 5'(lr);
    #1;
    v = ra_data;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cwp0;
    rst = 1; call = 0; ret = 0; we = 0; wa = 0; wd = 0;
    ra_addr = 0; rb_addr = 0; mem_ready = 0; mem_rdata = 0;
    m_cwp = 0; m_swp = 0; m_saved = 0; m_mode = 0; m_pos = 0; m_ovf = 0; m_unf = 0;
    for (int i = 0; i < R; i++) g_m[i] = 0;
    for (int i = 0; i < NW * F; i++) w_m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk(cwp == 0 && swp == 0, "R1 pointers", 32'({cwp, swp}), 32'h0);
    chk(!busy && !mem_valid && !ovf_trap && !unf_trap, "R1 idle flags",
        32'({busy, mem_valid, ovf_trap, unf_trap}), 32'h0);
    peek(19, v); chk(v == 0, "R1 register clear", v, 32'h0);
    @(negedge clk);

    // R2 / R3 / R13: globals and argument passing
    tick(0, 0, 1, 3, 32'h0000_00A5);
    tick(0, 0, 1, 25, 32'h0000_1234);
    tick(0, 0, 1, 17, 32'h0000_BEEF);
    tick(1, 0, 0, 0, 32'h0);
    peek(3, v);  chk(v == 32'hA5, "R2 global after call", v, 32'hA5);
    peek(9, v);  chk(v == 32'h1234, "R3 arg visible in callee", v, 32'h1234);
    peek(17, v); chk(v == 32'h0, "R4 callee locals fresh", v, 32'h0);
    tick(0, 0, 1, 17, 32'h0000_C0DE);
    tick(0, 0, 1, 10, 32'h0000_0777);
    tick(0, 1, 0, 0, 32'h0);
    peek(17, v); chk(v == 32'hBEEF, "R4 caller local back", v, 32'hBEEF);
    peek(26, v); chk(v == 32'h0777, "R3 result visible to caller", v, 32'h0777);

    // R8: return at the outermost frame with nothing saved
    tick(0, 1, 0, 0, 32'h0);
    chk(cwp == 0, "R8 outer return ignored", 32'(cwp), 32'h0);

    // R10: call and return together
    tick(1, 1, 0, 0, 32'h0);
    chk(cwp == 1, "R10 call wins", 32'(cwp), 32'h1);
    tick(0, 1, 0, 0, 32'h0);

    // R6 / R9 / R12: deep nesting with stalls, writes during busy
    rdy_pct = 60;
    for (int d = 0; d < 6; d++) begin
      tick(0, 0, 1, 16, 32'h100 + 32'(d));
      tick(0, 0, 1, 24, 32'h200 + 32'(d));
      if (d < 5) begin
        cwp0 = int'(cwp);
        tick(1, 0, 0, 0, 32'h0);
        if (m_mode != 0) begin
          tick(1, 0, 1, 5, 32'hDEAD);
          tick(0, 1, 1, 20, 32'hDEAD);
          idle_until_free();
          chk(int'(cwp) == (cwp0 + 1) % NW, "R9 single step after spill", 32'(cwp), 32'((cwp0 + 1) % NW));
          peek(5, v); chk(v == 32'h0, "R9 write dropped while busy", v, 32'h0);
        end
      end
    end
    cwp0 = int'(cwp);
    tick(1, 0, 0, 0, 32'h0);
    chk(!busy && int'(cwp) == cwp0, "R12 call ignored when stack full", 32'({busy, cwp}), 32'(cwp0));

    // R7: unwind through fills, checking each frame
    for (int d = 5; d >= 0; d--) begin
      peek(16, v); chk(v == 32'h100 + 32'(d), "R7 local restored", v, 32'h100 + 32'(d));
      if (d > 0) begin
        peek(8, v); chk(v == 32'h200 + 32'(d - 1), "R7 incoming restored", v, 32'h200 + 32'(d - 1));
        tick(0, 1, 0, 0, 32'h0);
        idle_until_free();
      end
    end

    // Random traffic, compared every clock
    rdy_pct = 70;
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 100);
      tick(op < 15, op >= 15 && op < 30, op >= 40, int'($urandom % 32), $urandom);
    end
    idle_until_free();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule